// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins (64 or 96, a multiple of 32). Software reaches it through a 32-bit register port. Each of the seven register functions takes up one bank of NUM_PINS/32 consecutive words, and each word covers 32 pins. Each pin can be read back as a synchronised level. Each pin can also be turned into an output whose value changes only through separate write-one set and write-one clear registers.

Every pin input passes through a two-flop synchroniser. Rising and falling transitions of the synchronised value can be enabled separately for each pin. An enabled transition latches a sticky status bit, and software clears that bit by writing a one to it. A single registered interrupt line stays high while any status bit is set.

The register port has no back-pressure. An access is presented for one cycle with `bus_sel` high and is always accepted. A write takes effect at that clock edge. Read data appears on `bus_rdata` in the following cycle, and `bus_rdata` is zero after any cycle without a read.

Top module: `bankgpio_ctrl`

## Requirements
- R1: After reset, all direction, output, rising-enable, falling-enable and status bits are 0, `pad_oe`, `pad_out` and `irq` are 0, and `bus_rdata` is 0.
- R2: With W = NUM_PINS/32, the functions take indices in this order: level 0, direction 1, set 2, clear 3, rising enable 4, falling enable 5, status 6. Pin p of function f sits at byte address f*W*4 + (p/32)*4, bit p mod 32. Read data is returned one cycle after the read is presented.
- R3: A write to a direction word replaces all 32 bits of that word. Bit value 1 makes the pin an output (`pad_oe` high) and 0 makes it an input. Direction words read back as written, and direction changes only on such a write.
- R4: Writing a 1 to a bit of a set word drives that pin's `pad_out` high. Zero bits leave their pins unchanged. Set words read as zero.
- R5: Writing a 1 to a bit of a clear word drives that pin's `pad_out` low. Zero bits leave their pins unchanged. Clear words read as zero.
- R6: A level word returns the pin input after two synchroniser flops, whatever the pin's direction. A read presented in the second cycle after the input changes still returns the old value, and a read presented in the third cycle returns the new one.
- R7: With rising enable set, a 0-to-1 transition of the synchronised input sets the pin's status bit. Transitions of pins whose matching enable is clear never set status.
- R8: Falling enable works on its own for each pin and catches 1-to-0 transitions. With both enables set, either transition sets the status bit.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, and 0 bits leave their status bits unchanged. If a new transition and a clearing write hit the same bit in the same cycle, the bit stays set.
- R10: `irq` is the OR of all status bits, delayed by one register stage. It stays high until every status bit has been cleared.
- R11: Writes to level words are ignored. Accesses to an address that is not a multiple of four, or that lies at or beyond byte 7*W*4, read as zero and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pad_in | input | NUM_PINS | Asynchronous pin inputs |
| pad_out | output | NUM_PINS | Pin output values |
| pad_oe | output | NUM_PINS | Pin output enables (direction) |
| irq | output | 1 | Combined edge interrupt |

## Verification
The edge logic is driven with single rising transitions, single falling transitions, transitions on pins with no enable, and pins with both enables set, in both words of the bank. These patterns separate the rising path, the falling path and the "either edge" combination, and show that status is not set spuriously. A clearing write is timed to land in the exact cycle a new edge latches, which tells set-wins priority apart from clear-wins priority. Output words are exercised with overlapping set and clear masks and zero masks, which distinguishes write-one semantics from plain overwrite. Level reads issued one cycle apart bracket the two-flop latency.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  localparam int BGC_FUNCS     = 7;
  localparam int BGC_WORD_BITS = 32;

  typedef enum logic [2:0] {
    FN_LEVEL = 3'd0,
    FN_DIR   = 3'd1,
    FN_SET   = 3'd2,
    FN_CLR   = 3'd3,
    FN_RISE  = 3'd4,
    FN_FALL  = 3'd5,
    FN_STAT  = 3'd6
  } bgc_fn_e;

  typedef struct packed {
    logic    hit;
    bgc_fn_e fn;
    logic [3:0] word;
  } bgc_acc_t;
endpackage

// File: rtl/bgc_decode.sv
module bgc_decode
  import bgc_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output bgc_acc_t          acc
);
  localparam int WORDS = NUM_PINS / BGC_WORD_BITS;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;

  always_comb begin
    widx     = addr[ADDR_W-1:2];
    acc.hit  = 1'b0;
    acc.fn   = FN_LEVEL;
    acc.word = '0;
    for (int f = 0; f < BGC_FUNCS; f++) begin
      for (int w = 0; w < WORDS; w++) begin
        if ((addr[1:0] == 2'b00) && (widx == IDX_W'(f * WORDS + w))) begin
          acc.hit  = 1'b1;
          acc.fn   = bgc_fn_e'(3'(f));
          acc.word = 4'(w);
        end
      end
    end
  end
endmodule

// File: rtl/bgc_sync_edge.sv
module bgc_sync_edge #(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] level,
  output logic [NUM_PINS-1:0] rise,
  output logic [NUM_PINS-1:0] fall
);
  logic [NUM_PINS-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/bgc_pin_regs.sv
module bgc_pin_regs
  import bgc_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bgc_acc_t            acc,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [31:0]         wdata,
  input  logic [NUM_PINS-1:0] level,
  input  logic [NUM_PINS-1:0] rise_evt,
  input  logic [NUM_PINS-1:0] fall_evt,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] rise_en_q,
  output logic [NUM_PINS-1:0] fall_en_q,
  output logic [NUM_PINS-1:0] stat_q,
  output logic [31:0]         rdata,
  output logic                irq
);
  localparam int WORDS = NUM_PINS / BGC_WORD_BITS;

  logic [WORDS-1:0]    sel_w;
  logic [NUM_PINS-1:0] dir_d, out_d, rise_d, fall_d, stat_d, clr_mask, det;
  logic [31:0]         rd_word;

  for (genvar w = 0; w < WORDS; w++) begin : g_sel
    assign sel_w[w] = acc.hit && (acc.word == 4'(w));
  end

  assign det = (rise_evt & rise_en_q) | (fall_evt & fall_en_q);

  always_comb begin
    dir_d    = dir_q;
    out_d    = out_q;
    rise_d   = rise_en_q;
    fall_d   = fall_en_q;
    clr_mask = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (wr_en && sel_w[w]) begin
        case (acc.fn)
          FN_DIR:  dir_d[w*32 +: 32]    = wdata;
          FN_SET:  out_d[w*32 +: 32]    = out_q[w*32 +: 32] | wdata;
          FN_CLR:  out_d[w*32 +: 32]    = out_q[w*32 +: 32] & ~wdata;
          FN_RISE: rise_d[w*32 +: 32]   = wdata;
          FN_FALL: fall_d[w*32 +: 32]   = wdata;
          FN_STAT: clr_mask[w*32 +: 32] = wdata;
          default: ;
        endcase
      end
    end
    stat_d = (stat_q & ~clr_mask) | det;
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (sel_w[w]) begin
        case (acc.fn)
          FN_LEVEL: rd_word = level[w*32 +: 32];
          FN_DIR:   rd_word = dir_q[w*32 +: 32];
          FN_RISE:  rd_word = rise_en_q[w*32 +: 32];
          FN_FALL:  rd_word = fall_en_q[w*32 +: 32];
          FN_STAT:  rd_word = stat_q[w*32 +: 32];
          default:  rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      stat_q    <= '0;
      rdata     <= '0;
      irq       <= 1'b0;
    end else begin
      dir_q     <= dir_d;
      out_q     <= out_d;
      rise_en_q <= rise_d;
      fall_en_q <= fall_d;
      stat_q    <= stat_d;
      rdata     <= rd_en ? rd_word : '0;
      irq       <= |stat_q;
    end
  end
endmodule

// File: rtl/bankgpio_ctrl.sv
module bankgpio_ctrl
  import bgc_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  bgc_acc_t            acc;
  logic                wr_en, rd_en;
  logic [NUM_PINS-1:0] level_w, rise_w, fall_w;
  logic [NUM_PINS-1:0] rise_en_w, fall_en_w, stat_w;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  bgc_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .acc  (acc)
  );

  bgc_sync_edge #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .level  (level_w),
    .rise   (rise_w),
    .fall   (fall_w)
  );

  bgc_pin_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (bus_wdata),
    .level     (level_w),
    .rise_evt  (rise_w),
    .fall_evt  (fall_w),
    .dir_q     (pad_oe),
    .out_q     (pad_out),
    .rise_en_q (rise_en_w),
    .fall_en_q (fall_en_w),
    .stat_q    (stat_w),
    .rdata     (bus_rdata),
    .irq       (irq)
  );
endmodule

// File: rtl/bankgpio_ctrl_chk.sv
module bankgpio_ctrl_chk #(
  parameter int NUM_PINS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                irq,
  input logic [NUM_PINS-1:0] stat,
  input logic [NUM_PINS-1:0] en_any
);
  a_r3_dir_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(pad_oe));

  a_r4_out_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(pad_out));

  a_r7_new_status_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat)) & ~$past(en_any)) == '0);

  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ((stat & $past(stat)) == $past(stat)));

  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|stat));
endmodule

bind bankgpio_ctrl bankgpio_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_sel (bus_sel),
  .bus_wr  (bus_wr),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .irq     (irq),
  .stat    (stat_w),
  .en_any  (rise_en_w | fall_en_w)
);

// File: tb/bankgpio_ctrl_test.sv
module bankgpio_ctrl_test;
  localparam int N     = 64;
  localparam int AW    = 8;
  localparam int WORDS = N / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bankgpio_ctrl #(.NUM_PINS(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [AW-1:0] a_of(int f, int w);
    return AW'(f * WORDS * 4 + w * 4);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic quiesce();
    for (int w = 0; w < WORDS; w++) begin
      wr(a_of(4, w), 32'h0);
      wr(a_of(5, w), 32'h0);
    end
    pad_in = '0;
    tick(4);
    for (int w = 0; w < WORDS; w++) wr(a_of(6, w), 32'hFFFF_FFFF);
    tick(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 irq", irq, 0);
    chk("R1 rdata", bus_rdata, 0);
    for (int f = 0; f < 7; f++)
      for (int w = 0; w < WORDS; w++) begin
        rd(a_of(f, w), d);
        chk("R1 register zero", d, 0);
      end
  endtask

  task automatic t_dir();
    logic [31:0] d;
    wr(a_of(1, 1), 32'hA5A5_0F0F);
    rd(a_of(1, 1), d);
    chk("R3 dir readback", d, 32'hA5A5_0F0F);
    rd(a_of(1, 0), d);
    chk("R2 dir other word", d, 0);
    chk("R3 pad_oe", pad_oe, {32'hA5A5_0F0F, 32'h0});
    wr(a_of(1, 0), 32'h0000_0001);
    chk("R2 dir word0 bit0", pad_oe, {32'hA5A5_0F0F, 32'h1});
    tick(1);
    d = bus_rdata;
    chk("R2 rdata zero when idle", d, 0);
  endtask

  task automatic t_set_clr();
    logic [31:0] d;
    wr(a_of(2, 0), 32'h0000_00FF);
    chk("R4 set low byte", pad_out, 64'h0000_00FF);
    wr(a_of(2, 0), 32'h0000_0100);
    chk("R4 zeros keep", pad_out, 64'h0000_01FF);
    wr(a_of(3, 0), 32'h0000_000F);
    chk("R5 clear nibble", pad_out, 64'h0000_01F0);
    wr(a_of(2, 1), 32'h8000_0000);
    chk("R2 set word1 bit31", pad_out, 64'h8000_0000_0000_01F0);
    wr(a_of(3, 1), 32'h0);
    chk("R5 zero clear no effect", pad_out, 64'h8000_0000_0000_01F0);
    rd(a_of(2, 0), d);
    chk("R4 set reads zero", d, 0);
    rd(a_of(3, 1), d);
    chk("R5 clear reads zero", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    pad_in = 64'h1234_5678_9ABC_DEF0;
    rd(a_of(0, 0), d);
    chk("R6 level first cycle old", d, 0);
    rd(a_of(0, 0), d);
    chk("R6 level second cycle old", d, 0);
    rd(a_of(0, 0), d);
    chk("R6 level third cycle new", d, 32'h9ABC_DEF0);
    rd(a_of(0, 1), d);
    chk("R6 level on output pins", d, 32'h1234_5678);
    wr(a_of(0, 0), 32'hFFFF_FFFF);
    rd(a_of(0, 0), d);
    chk("R11 level write ignored", d, 32'h9ABC_DEF0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    quiesce();
    wr(a_of(4, 0), 32'h0000_0008);
    wr(a_of(4, 1), 32'h0000_0100);
    pad_in[3] = 1'b1;
    tick(3);
    chk("R10 irq registered late", irq, 0);
    tick(1);
    chk("R10 irq set", irq, 1);
    rd(a_of(6, 0), d);
    chk("R7 rise pin3", d, 32'h8);
    rd(a_of(6, 1), d);
    chk("R7 word1 untouched", d, 0);
    pad_in[40] = 1'b1;
    tick(4);
    rd(a_of(6, 1), d);
    chk("R7 rise pin40", d, 32'h100);
    pad_in[3] = 1'b0;
    pad_in[4] = 1'b1;
    tick(4);
    rd(a_of(6, 0), d);
    chk("R7 disabled edges ignored", d, 32'h8);
    wr(a_of(6, 0), 32'h8);
    tick(2);
    chk("R10 irq held by word1", irq, 1);
    wr(a_of(6, 1), 32'h100);
    tick(2);
    chk("R10 irq dropped", irq, 0);
  endtask

  task automatic t_fall_both();
    logic [31:0] d;
    quiesce();
    pad_in[5] = 1'b1;
    pad_in[6] = 1'b1;
    tick(4);
    wr(a_of(5, 0), 32'h0000_0060);
    wr(a_of(4, 0), 32'h0000_0040);
    pad_in[5] = 1'b0;
    tick(4);
    rd(a_of(6, 0), d);
    chk("R8 fall pin5", d, 32'h20);
    pad_in[6] = 1'b0;
    tick(4);
    rd(a_of(6, 0), d);
    chk("R8 both pin6 falling", d, 32'h60);
    wr(a_of(6, 0), 32'h60);
    pad_in[5] = 1'b1;
    tick(4);
    rd(a_of(6, 0), d);
    chk("R8 rise on fall-only pin ignored", d, 0);
    pad_in[6] = 1'b1;
    tick(4);
    rd(a_of(6, 0), d);
    chk("R8 both pin6 rising", d, 32'h40);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pad_in[6] = 1'b0;
    tick(2);
    wr(a_of(6, 0), 32'h40);
    rd(a_of(6, 0), d);
    chk("R9 set wins over clear", d, 32'h40);
    wr(a_of(6, 0), 32'h0);
    rd(a_of(6, 0), d);
    chk("R9 zero write keeps", d, 32'h40);
    pad_in[5] = 1'b0;
    tick(4);
    rd(a_of(6, 0), d);
    chk("R9 two bits pending", d, 32'h60);
    wr(a_of(6, 0), 32'h20);
    rd(a_of(6, 0), d);
    chk("R9 partial clear", d, 32'h40);
    wr(a_of(6, 0), 32'h40);
    rd(a_of(6, 0), d);
    chk("R9 full clear", d, 0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    logic [63:0] oe0, out0;
    oe0 = pad_oe;
    out0 = pad_out;
    wr(AW'(7 * WORDS * 4), 32'hFFFF_FFFF);
    wr(AW'(7 * WORDS * 4 + 4), 32'hFFFF_FFFF);
    wr(AW'(252), 32'hFFFF_FFFF);
    wr(a_of(2, 0) + AW'(1), 32'hFFFF_FFFF);
    wr(a_of(1, 0) + AW'(2), 32'hFFFF_FFFF);
    chk("R11 oe unchanged", pad_oe, oe0);
    chk("R11 out unchanged", pad_out, out0);
    rd(AW'(7 * WORDS * 4), d);
    chk("R11 beyond reads zero", d, 0);
    rd(a_of(1, 1) + AW'(1), d);
    chk("R11 unaligned reads zero", d, 0);
    rd(a_of(1, 1), d);
    chk("R11 dir word1 kept", d, 32'hA5A5_0F0F);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_dir();
    t_set_clr();
    t_level();
    t_rise();
    t_fall_both();
    t_w1c();
    t_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule